// File: doc/BRIEF.md
# Weighted Two-Queue Transmit Arbiter

The arbiter picks which of two transmit queues, a high-priority one and a low-priority one, supplies the next packet to a shared transmitter. Each queue reports only whether it holds anything. A 3-bit weight code sets how many high packets are served for each low packet. The mapping is not linear: code 0 gives one high packet per low packet, codes 1 to 6 give 2, 4, 6, 8, 10 and 12, and code 7 gives strict priority to the high queue. The transmitter pulses a packet-done strobe when the granted packet ends. A decision is taken only at that strobe, or at once while nothing is granted. The decision then holds for the whole packet.

A saturating counter records the high packets served since the last low packet. When a low packet completes, the counter clears. It also clears whenever the high queue is found empty at a boundary or while high is not being served, so a fresh burst of high traffic starts its quota from zero. If the low queue is empty when its turn comes, high service continues. The count stays at or above the quota, so the low queue wins at the first boundary after it fills.

The controller has three states. `ST_IDLE` means no grant. `ST_HIGH` grants the high queue and `ST_LOW` grants the low queue. From `ST_IDLE` the arbiter moves in one cycle to `ST_HIGH` or `ST_LOW` as soon as either queue is non-empty. From `ST_HIGH` or `ST_LOW`, a packet-done strobe re-runs the pick. The pick may select `ST_HIGH`, `ST_LOW`, or `ST_IDLE` when both queues are empty. Without the strobe a serving state holds.

Top module: `tx_wrr_arbiter`

## Requirements
- R1: After reset the grant is 2'b00 and grant_valid is low.
- R2: grant[0] means the high queue is granted and grant[1] means the low queue is granted. At most one bit is set, and grant_valid equals the OR of the bits.
- R3: While nothing is granted and a queue is non-empty, a grant appears after the next rising clock edge. The high queue is preferred when both queues are non-empty and the count is zero.
- R4: A grant stays unchanged on every cycle without pkt_done, even if the queue flags or the weight change.
- R5: A decision never grants a queue whose non-empty flag is low in the decision cycle. If both flags are low at a boundary, the arbiter goes idle.
- R6: With weight code c in 0..6 and both queues kept non-empty, the grant sequence repeats Q high packets, then one low packet. Q is 1 for c=0 and 2*c otherwise.
- R7: With weight code 7, the high queue wins every decision in which it is non-empty. The low queue is granted only when the high queue is empty.
- R8: If the high queue is empty at a boundary or while high is not granted, the high count returns to zero. The next high run then starts a full quota.
- R9: If the low queue is empty when the quota is reached, high packets continue to be granted. The low queue is granted at the first boundary after its flag rises.
- R10: The weight code is sampled only at decisions. A change during a packet affects the next boundary.
- R11: A pkt_done pulse while nothing is granted has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_ready | input | 1 | High queue holds at least one packet |
| lo_ready | input | 1 | Low queue holds at least one packet |
| weight | input | W_W | Weight code (0..6 quota, all-ones strict) |
| pkt_done | input | 1 | One-cycle strobe at end of granted packet |
| grant | output | 2 | One-hot grant: bit 0 high, bit 1 low |
| grant_valid | output | 1 | A queue is currently granted |

## Verification
The bench builds the block with the default 3-bit weight field, so the counter is 4 bits wide. Every code from 0 to 7 is therefore reachable, including the largest quota of 12. Each code from 0 to 6 is run for two full periods with both queues busy. The bench also drives the high queue draining mid-quota, the low queue arriving only after its turn has passed, and the weight being rewritten in the middle of a packet. These cases bring the counter clear, the saturation, and the boundary-only sampling of the weight into view at the grant pins.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } arb_state_e;

    localparam logic [1:0] GNT_NONE = 2'b00;
    localparam logic [1:0] GNT_HIGH = 2'b01;
    localparam logic [1:0] GNT_LOW  = 2'b10;
endpackage

// File: rtl/wrr_quota_decode.sv
module wrr_quota_decode #(
    parameter int W_W   = 3,
    parameter int CNT_W = W_W + 1
) (
    input  logic [W_W-1:0]   code,
    output logic [CNT_W-1:0] quota,
    output logic             strict
);
    // Code 0 -> one high packet; code c -> 2*c; all-ones -> strict priority.
    always_comb begin
        strict = &code;
        if (code == '0) begin
            quota = CNT_W'(1);
        end else begin
            quota = CNT_W'({code, 1'b0});
        end
    end
endmodule

// File: rtl/wrr_hi_counter.sv
module wrr_hi_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_d
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R8: a clear request leaves the count at zero on the next cycle
    p_count_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R9: with neither request the count holds (saturation keeps it put)
    p_count_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/tx_wrr_arbiter.sv
module tx_wrr_arbiter
    import wrr_pkg::*;
#(
    parameter int W_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hi_ready,
    input  logic           lo_ready,
    input  logic [W_W-1:0] weight,
    input  logic           pkt_done,
    output logic [1:0]     grant,
    output logic           grant_valid
);
    localparam int CNT_W = W_W + 1;

    arb_state_e       state_q, state_d;
    logic [CNT_W-1:0] quota;
    logic             strict;
    logic [CNT_W-1:0] cnt_d;
    logic             boundary, hi_done, lo_done;
    logic             cnt_clr, cnt_inc, quota_met;

    wrr_quota_decode #(.W_W(W_W), .CNT_W(CNT_W)) u_quota (
        .code   (weight),
        .quota  (quota),
        .strict (strict)
    );

    always_comb begin
        boundary = (state_q == ST_IDLE) || pkt_done;
        hi_done  = (state_q == ST_HIGH) && pkt_done;
        lo_done  = (state_q == ST_LOW) && pkt_done;
        cnt_inc  = hi_done && hi_ready;
        cnt_clr  = lo_done || (!hi_ready && ((state_q != ST_HIGH) || pkt_done));
    end

    wrr_hi_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt_d (cnt_d)
    );

    assign quota_met = !strict && (cnt_d >= quota);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (boundary) begin
            if (hi_ready && lo_ready) begin
                state_d = quota_met ? ST_LOW : ST_HIGH;
            end else if (hi_ready) begin
                state_d = ST_HIGH;
            end else if (lo_ready) begin
                state_d = ST_LOW;
            end else begin
                state_d = ST_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: grant = GNT_NONE;
            ST_HIGH: grant = GNT_HIGH;
            ST_LOW:  grant = GNT_LOW;
            default: grant = GNT_NONE;
        endcase
        grant_valid = (state_q != ST_IDLE);
    end

    // R2: one-hot grant consistent with the valid flag
    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == (grant != 2'b00)));

    // R3: an idle arbiter with work grants on the next cycle
    p_idle_grants_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (hi_ready || lo_ready)) |=> grant_valid);

    // R4: grant held through the packet
    p_grant_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !pkt_done) |=> $stable(grant));

    // R5: a fresh high grant requires a non-empty high queue
    p_no_empty_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid || pkt_done) |=> (!grant[0] || $past(hi_ready)));

    // R5: a fresh low grant requires a non-empty low queue
    p_no_empty_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid || pkt_done) |=> (!grant[1] || $past(lo_ready)));

    // R7: strict code always picks a waiting high queue
    p_strict_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((weight == '1) && hi_ready && (!grant_valid || pkt_done)) |=> grant[0]);
endmodule

// File: tb/sim_tx_wrr_arbiter.sv
module sim_tx_wrr_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_ready = 1'b0;
    logic       lo_ready = 1'b0;
    logic [2:0] weight = 3'd0;
    logic       pkt_done = 1'b0;
    logic [1:0] grant;
    logic       grant_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [1:0] exp_g[$];
    string      exp_tag[$];

    always #2 clk = ~clk;

    tx_wrr_arbiter #(.W_W(3)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_ready    (hi_ready),
        .lo_ready    (lo_ready),
        .weight      (weight),
        .pkt_done    (pkt_done),
        .grant       (grant),
        .grant_valid (grant_valid)
    );

    // Monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (exp_g.size() > 0) begin
            logic [1:0] e;
            string      t;
            e = exp_g.pop_front();
            t = exp_tag.pop_front();
            checks++;
            if (grant !== e || grant_valid !== (e != 2'b00)) begin
                errors++;
                $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                         t, grant, grant_valid, e, (e != 2'b00));
            end
        end
    end

    task automatic push(input logic [1:0] g, input string t);
        exp_g.push_back(g);
        exp_tag.push_back(t);
    endtask

    task automatic step_expect(input logic [1:0] g, input string t);
        @(posedge clk);
        #1;
        push(g, t);
    endtask

    task automatic done_pulse(input logic [1:0] g, input string t);
        @(negedge clk);
        pkt_done = 1'b1;
        @(posedge clk);
        #1;
        pkt_done = 1'b0;
        push(g, t);
    endtask

    task automatic set_q(input logic h, input logic l);
        @(negedge clk);
        hi_ready = h;
        lo_ready = l;
    endtask

    task automatic drain();
        set_q(1'b0, 1'b0);
        done_pulse(2'b00, "R5");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R11 strobe while idle
        step_expect(2'b00, "R1");
        done_pulse(2'b00, "R11");

        // R3 idle grant, R4 hold
        set_q(1'b1, 1'b1);
        step_expect(2'b01, "R3");
        step_expect(2'b01, "R4");
        step_expect(2'b01, "R4");

        // R6 quota periods for codes 0..6
        for (int c = 0; c < 7; c++) begin
            int q;
            q = (c == 0) ? 1 : 2 * c;
            drain();
            @(negedge clk);
            weight = 3'(c);
            set_q(1'b1, 1'b1);
            step_expect(2'b01, "R6");
            for (int k = 1; k < 2 * (q + 1); k++) begin
                done_pulse(((k % (q + 1)) < q) ? 2'b01 : 2'b10, "R6");
            end
        end

        // R7 strict priority
        drain();
        @(negedge clk);
        weight = 3'd7;
        set_q(1'b1, 1'b1);
        step_expect(2'b01, "R7");
        for (int k = 0; k < 10; k++) begin
            done_pulse(2'b01, "R7");
        end
        set_q(1'b0, 1'b1);
        done_pulse(2'b10, "R7");
        // R5 both empty at boundary -> idle; low-only idle grant
        set_q(1'b0, 1'b0);
        done_pulse(2'b00, "R5");
        set_q(1'b0, 1'b1);
        step_expect(2'b10, "R5");

        // R8 high drains mid-quota, count restarts
        drain();
        @(negedge clk);
        weight = 3'd1;
        set_q(1'b1, 1'b0);
        step_expect(2'b01, "R8");
        done_pulse(2'b01, "R8");
        set_q(1'b0, 1'b0);
        done_pulse(2'b00, "R8");
        set_q(1'b1, 1'b1);
        step_expect(2'b01, "R8");
        done_pulse(2'b01, "R8");
        done_pulse(2'b10, "R8");

        // R9 low empty at its turn
        drain();
        @(negedge clk);
        weight = 3'd0;
        set_q(1'b1, 1'b0);
        step_expect(2'b01, "R9");
        done_pulse(2'b01, "R9");
        done_pulse(2'b01, "R9");
        set_q(1'b1, 1'b1);
        done_pulse(2'b10, "R9");
        done_pulse(2'b01, "R9");

        // R10 weight change mid-packet
        drain();
        @(negedge clk);
        weight = 3'd6;
        set_q(1'b1, 1'b1);
        step_expect(2'b01, "R10");
        done_pulse(2'b01, "R10");
        @(negedge clk);
        weight = 3'd0;
        step_expect(2'b01, "R4");
        step_expect(2'b01, "R10");
        done_pulse(2'b10, "R10");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R4: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule